// File: doc/BRIEF.md
# Serial Prefix-Code Symbol Decoder

This block turns a serial stream of variable-length prefix codewords into symbol indices. One coded bit arrives per cycle on a valid/ready input. A walker holds its position in a fixed binary code tree and steps on each accepted bit, taking the left branch on 0 and the right branch on 1. When a step lands on a leaf, the walker returns to the root on that same clock edge. The symbol index is then presented on a valid/ready output.

The alphabet has five symbols with indices 0 to 4. Index 0 has the one-bit codeword `0`. Indices 1, 2, 3 and 4 have the three-bit codewords `100`, `101`, `110` and `111`. The bits are sent first bit first, so the leading `1` in each three-bit codeword is the bit sent first. Because the code is prefix-free, a symbol is complete as soon as its last bit is taken, with no lookahead.

Back-pressure rules are as follows. The output register holds one symbol. While that symbol waits with `sym_ready` low, `bit_ready` is low and no input bit is taken. A bit is consumed only on a cycle where `bit_valid` and `bit_ready` are both high. When `sym_ready` is held high, each symbol appears on `sym_valid` for exactly one cycle.

Top module: `pfx_sym_decoder`

## Requirements
- R1: Synchronous reset puts the walker at the root and clears `sym_valid`. A partial codeword in progress is discarded. After reset, `bit_ready` is 1.
- R2: An accepted 0 bit at the root makes `sym_valid` 1 with `sym` = 0 on the next cycle.
- R3: The accepted bit sequences 100, 101, 110 and 111 (first bit first) make `sym` equal to 1, 2, 3 and 4. The symbol appears in the cycle after the third bit is accepted.
- R4: After a leaf the walker is back at the root on the same edge. Codewords sent with no idle bits therefore produce symbols with no idle decode cycle between them.
- R5: A cycle with `bit_valid` low consumes nothing. The value on `bit_in` in that cycle has no effect, and the tree position is held.
- R6: With `sym_ready` high, each decoded symbol holds `sym_valid` high for exactly one cycle.
- R7: While `sym_valid` is 1 and `sym_ready` is 0, `sym_valid` and `sym` hold their values.
- R8: While a symbol is stalled (`sym_valid` 1, `sym_ready` 0), `bit_ready` is 0. A bit offered during the stall is not consumed until the stall ends.
- R9: An accepted bit that does not complete a codeword is followed by `sym_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Coded bit |
| bit_valid | input | 1 | `bit_in` is valid |
| bit_ready | output | 1 | Block can take a bit this cycle |
| sym | output | SYM_W | Decoded symbol index, 0 to 4 |
| sym_valid | output | 1 | `sym` holds a decoded symbol |
| sym_ready | input | 1 | Downstream accepts `sym` |

## Verification
The bench builds the block with its default 3-bit symbol width. That width covers all five indices, so every leaf of the tree is reachable, including both the one-bit and the three-bit codeword lengths. Directed tests cover the following:
- reset in the middle of a codeword;
- idle cycles inside a codeword while `bit_in` toggles;
- stalls on the output side while a new bit is offered;
- codewords sent with no idle bits between them.

A long run of random symbols with random idle gaps is encoded with the same table and compared in order against the decoded stream.

// File: rtl/pfx_dec_pkg.sv
package pfx_dec_pkg;
  localparam int SYM_W_DEF = 3;

  // Tree positions: root and the three interior nodes below it.
  typedef enum logic [1:0] {
    N_ROOT = 2'd0,
    N_R    = 2'd1,
    N_RL   = 2'd2,
    N_RR   = 2'd3
  } node_e;

  // Symbol index bases at each leaf group.
  localparam int IDX_SHORT = 0;
  localparam int IDX_RL    = 1;
  localparam int IDX_RR    = 3;
endpackage

// File: rtl/pfx_tree_step.sv
module pfx_tree_step
  import pfx_dec_pkg::*;
#(
  parameter int SYM_W = SYM_W_DEF
) (
  input  node_e            cur,
  input  logic             bit_in,
  output node_e            nxt,
  output logic             leaf,
  output logic [SYM_W-1:0] sym
);
  localparam logic [SYM_W-1:0] B_SHORT = SYM_W'(IDX_SHORT);
  localparam logic [SYM_W-1:0] B_RL    = SYM_W'(IDX_RL);
  localparam logic [SYM_W-1:0] B_RR    = SYM_W'(IDX_RR);

  always_comb begin
    nxt  = N_ROOT;
    leaf = 1'b0;
    sym  = '0;
    unique case (cur)
      N_ROOT: begin
        if (bit_in) nxt = N_R;
        else begin
          leaf = 1'b1;
          sym  = B_SHORT;
        end
      end
      N_R: nxt = bit_in ? N_RR : N_RL;
      N_RL: begin
        leaf = 1'b1;
        sym  = B_RL + SYM_W'(bit_in);
      end
      N_RR: begin
        leaf = 1'b1;
        sym  = B_RR + SYM_W'(bit_in);
      end
      default: nxt = N_ROOT;
    endcase
  end
endmodule

// File: rtl/pfx_walker.sv
module pfx_walker
  import pfx_dec_pkg::*;
#(
  parameter int SYM_W = SYM_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             bit_in,
  output logic             leaf,
  output logic [SYM_W-1:0] leaf_sym
);
  node_e pos_q, pos_n;

  pfx_tree_step #(.SYM_W(SYM_W)) step_i (
    .cur    (pos_q),
    .bit_in (bit_in),
    .nxt    (pos_n),
    .leaf   (leaf),
    .sym    (leaf_sym)
  );

  always_ff @(posedge clk) begin
    if (rst)       pos_q <= N_ROOT;
    else if (take) pos_q <= pos_n;
  end
endmodule

// File: rtl/pfx_out_reg.sv
module pfx_out_reg #(
  parameter int SYM_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SYM_W-1:0] load_sym,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_sym,
  output logic             can_load
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sym   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_sym   <= load_sym;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pfx_sym_decoder.sv
module pfx_sym_decoder
  import pfx_dec_pkg::*;
#(
  parameter int SYM_W = SYM_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_valid,
  output logic             bit_ready,
  output logic [SYM_W-1:0] sym,
  output logic             sym_valid,
  input  logic             sym_ready
);
  logic             take;
  logic             leaf;
  logic [SYM_W-1:0] leaf_sym;
  logic             room;

  assign bit_ready = room;
  assign take      = bit_valid && room;

  pfx_walker #(.SYM_W(SYM_W)) walk_i (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .bit_in   (bit_in),
    .leaf     (leaf),
    .leaf_sym (leaf_sym)
  );

  pfx_out_reg #(.SYM_W(SYM_W)) oreg_i (
    .clk       (clk),
    .rst       (rst),
    .load      (take && leaf),
    .load_sym  (leaf_sym),
    .out_ready (sym_ready),
    .out_valid (sym_valid),
    .out_sym   (sym),
    .can_load  (room)
  );
endmodule

// File: rtl/pfx_sym_decoder_chk.sv
module pfx_sym_decoder_chk #(
  parameter int SYM_W   = 3,
  parameter int MAX_LEN = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_in,
  input logic             bit_valid,
  input logic             bit_ready,
  input logic [SYM_W-1:0] sym,
  input logic             sym_valid,
  input logic             sym_ready
);
  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_LEN - 1);

  logic             acc;
  logic [CNT_W-1:0] depth;
  logic             ends_now;

  assign acc      = bit_valid && bit_ready;
  assign ends_now = (depth == '0 && !bit_in) || (depth == LAST);

  always_ff @(posedge clk) begin
    if (rst)           depth <= '0;
    else if (acc)      depth <= ends_now ? '0 : depth + 1'b1;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> !sym_valid);

  // R2
  short_code_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && depth == '0 && !bit_in) |=> (sym_valid && sym == '0));

  // R3
  long_code_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && depth == LAST) |=> (sym_valid && sym != '0 && sym <= SYM_W'(4)));

  // R9
  no_early_sym_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !ends_now) |=> !sym_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym)));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && !sym_ready) |-> !bit_ready);
endmodule

bind pfx_sym_decoder pfx_sym_decoder_chk #(.SYM_W(SYM_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bit_in    (bit_in),
  .bit_valid (bit_valid),
  .bit_ready (bit_ready),
  .sym       (sym),
  .sym_valid (sym_valid),
  .sym_ready (sym_ready)
);

// File: tb/pfx_sym_decoder_tb_top.sv
module pfx_sym_decoder_tb_top;
  localparam int SYM_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic bit_valid = 1'b0;
  logic sym_ready = 1'b1;
  logic bit_ready;
  logic sym_valid;
  logic [SYM_W-1:0] sym;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int got_sym[$];
  int got_cyc[$];
  int vcycles = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pfx_sym_decoder #(.SYM_W(SYM_W)) dut_i (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .sym(sym), .sym_valid(sym_valid), .sym_ready(sym_ready)
  );

  // Monitor: log handshaked symbols and count valid cycles.
  always @(negedge clk) begin
    if (!rst && sym_valid) vcycles <= vcycles + 1;
    if (!rst && sym_valid && sym_ready) begin
      got_sym.push_back(int'(sym));
      got_cyc.push_back(cyc);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int code_len(input int s);
    return (s == 0) ? 1 : 3;
  endfunction

  // Codeword bit k, first bit sent is k=0.
  function automatic bit code_bit(input int s, input int k);
    int v;
    if (s == 0) return 1'b0;
    v = 4 + (s - 1);
    return v[2 - k];
  endfunction

  task automatic send_bit(input bit b);
    @(negedge clk);
    bit_in = b;
    bit_valid = 1'b1;
    while (!bit_ready) @(negedge clk);
    @(posedge clk);
    #1 bit_valid = 1'b0;
  endtask

  task automatic send_sym(input int s);
    for (int k = 0; k < code_len(s); k++) send_bit(code_bit(s, k));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_log();
    got_sym.delete();
    got_cyc.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bit_valid = 1'b0;
    sym_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(sym_valid == 1'b0, "R1", "sym_valid after reset", int'(sym_valid), 0);
    chk(bit_ready == 1'b1, "R1", "bit_ready after reset", int'(bit_ready), 1);
    clear_log();
    send_bit(1'b1);
    do_reset();
    clear_log();
    send_bit(1'b0);
    idle(2);
    chk(got_sym.size() == 1 && got_sym[0] == 0, "R1", "symbol after mid-code reset",
        got_sym.size() > 0 ? got_sym[0] : -1, 0);
  endtask

  task automatic t_short();
    int v0;
    clear_log();
    v0 = vcycles;
    send_bit(1'b0);
    idle(3);
    chk(got_sym.size() == 1 && got_sym[0] == 0, "R2", "short code symbol",
        got_sym.size() > 0 ? got_sym[0] : -1, 0);
    chk(vcycles - v0 == 1, "R6", "valid cycles per symbol", vcycles - v0, 1);
  endtask

  task automatic t_long();
    for (int s = 1; s <= 4; s++) begin
      clear_log();
      send_sym(s);
      idle(2);
      chk(got_sym.size() == 1 && got_sym[0] == s, "R3", "long code symbol",
          got_sym.size() > 0 ? got_sym[0] : -1, s);
    end
  endtask

  task automatic t_b2b();
    clear_log();
    @(negedge clk);
    bit_in = 1'b0;
    bit_valid = 1'b1;
    idle(3);
    bit_valid = 1'b0;
    idle(2);
    chk(got_sym.size() == 3, "R4", "back-to-back symbol count", got_sym.size(), 3);
    if (got_sym.size() == 3)
      chk(got_cyc[2] - got_cyc[0] == 2, "R4", "cycle spread of three symbols",
          got_cyc[2] - got_cyc[0], 2);
    clear_log();
    send_sym(2);
    send_sym(0);
    send_sym(4);
    idle(2);
    chk(got_sym.size() == 3 && got_sym[0] == 2 && got_sym[1] == 0 && got_sym[2] == 4,
        "R4", "mixed back-to-back sequence", got_sym.size(), 3);
  endtask

  task automatic t_gap();
    clear_log();
    send_bit(1'b1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      bit_in = i[0];
    end
    chk(got_sym.size() == 0, "R9", "no symbol mid-codeword", got_sym.size(), 0);
    send_bit(1'b1);
    idle(3);
    chk(got_sym.size() == 0, "R5", "no symbol after 2 of 3 bits with gaps", got_sym.size(), 0);
    send_bit(1'b0);
    idle(2);
    chk(got_sym.size() == 1 && got_sym[0] == 3, "R5", "symbol across idle gaps",
        got_sym.size() > 0 ? got_sym[0] : -1, 3);
  endtask

  task automatic t_stall();
    clear_log();
    @(negedge clk);
    sym_ready = 1'b0;
    send_bit(1'b0);
    @(negedge clk);
    bit_in = 1'b0;
    bit_valid = 1'b1;
    idle(3);
    chk(sym_valid == 1'b1 && sym == 0, "R7", "held symbol during stall", int'(sym), 0);
    chk(bit_ready == 1'b0, "R8", "bit_ready during stall", int'(bit_ready), 0);
    chk(got_sym.size() == 0, "R8", "nothing handshaked during stall", got_sym.size(), 0);
    sym_ready = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
    idle(3);
    chk(got_sym.size() == 2 && got_sym[1] == 0, "R8", "offered bit consumed after stall",
        got_sym.size(), 2);
  endtask

  task automatic t_random();
    int exp_q[$];
    int s;
    int bad;
    clear_log();
    for (int n = 0; n < 300; n++) begin
      s = $urandom_range(0, 4);
      exp_q.push_back(s);
      for (int k = 0; k < code_len(s); k++) begin
        send_bit(code_bit(s, k));
        if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 2));
      end
    end
    idle(3);
    chk(got_sym.size() == exp_q.size(), "R3", "random stream length", got_sym.size(), exp_q.size());
    bad = 0;
    for (int i = 0; i < exp_q.size() && i < got_sym.size(); i++)
      if (got_sym[i] != exp_q[i]) bad++;
    chk(bad == 0, "R2", "random stream mismatches", bad, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_short();
        t_long();
        t_b2b();
        t_gap();
        t_stall();
        t_random();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule